// File: doc/BRIEF.md
# Frame Type Acknowledge Policy Unit

This block sits on the receive side of a serial storage link. It sees each incoming frame one 32-bit word at a time. It reads the type byte from the first word and looks it up in a small programmable table of 2-bit policy codes. From that code it decides how the frame is acknowledged to the far end. There are three possible outcomes.

- **Accept:** the frame is acknowledged good, or bad if any word carried the error flag.
- **Reject:** the frame is acknowledged bad in every case.
- **Hold:** the frame is held for host software. Software reads the first two captured words and then commands accept or reject.

The error flag comes from an upstream integrity checker. This block does not compute the check itself. Types outside the table range take a separately programmed default code. Each acknowledgement is a one-cycle pulse, either good or bad. The link layer turns that pulse into the matching primitive.

Top module: `rx_type_policy`

## Requirements
- R1: After reset, both acknowledge outputs and the hold flag are low. Every table entry holds code 00 and the default code is 01.
- R2: The frame type is bits [7:0] of the word marked start-of-frame. Types below NUM_TYPES (default 16) use their own table entry. All other types use the default code.
- R3: Code 00 (accept) gives exactly one pulse in the cycle after the end-of-frame word. The pulse is on the good output when no word of the frame had the error flag set, and on the bad output otherwise. The two outputs are never high together.
- R4: Code 01 (reject) gives a single bad pulse in the cycle after the end-of-frame word and never a good pulse.
- R5: Code 11 is treated exactly like code 01.
- R6: Code 10 (hold) captures the first two words on the header outputs. The hold flag rises in the cycle after the second word. For a one-word frame it rises in the cycle after the end-of-frame word. The flag is high only while a held frame is in progress.
- R7: A held frame gives no acknowledge until a host command is taken. A command is taken in a cycle where the hold flag is high. The good or bad pulse then comes in the cycle after the later of the command and the end-of-frame word. A reject command wins over an accept command given in the same cycle.
- R8: If any word of a held frame carried the error flag, the pulse is bad even when the host commanded accept.
- R9: A host command given while the hold flag is low is ignored, and the hold flag falls only on a taken command.
- R10: A table write in the same cycle as a start-of-frame word for the same type does not change the policy of that frame. It takes effect for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one table entry |
| cfg_type | input | 8 | Type whose entry is written |
| cfg_code | input | 2 | Policy code to write |
| cfg_dflt_we | input | 1 | Write the default code |
| cfg_dflt_code | input | 2 | Default code for out-of-range types |
| rx_valid | input | 1 | Receive word present |
| rx_sof | input | 1 | Word is the first of a frame |
| rx_eof | input | 1 | Word is the last of a frame |
| rx_err | input | 1 | Error flagged on this word |
| rx_data | input | 32 | Receive word |
| host_accept | input | 1 | Host accepts the held frame |
| host_reject | input | 1 | Host rejects the held frame |
| hold_pending | output | 1 | Held frame awaits host command |
| hdr_dw0 | output | 32 | First captured word |
| hdr_dw1 | output | 32 | Second captured word |
| send_rok | output | 1 | Good acknowledge pulse |
| send_rerr | output | 1 | Bad acknowledge pulse |

## Verification
The host command and the end-of-frame word of a held frame can arrive in the same cycle. The host command can also arrive before the end-of-frame word, and then the acknowledge must wait for it. The bench drives a three-word held frame with the accept command on the final word. It expects the good pulse exactly one cycle later. It runs a five-word frame whose command comes mid-frame and checks that nothing is sent before the end-of-frame word. A table write that lands on a start-of-frame word is also forced, and the policy used is checked against the code that was held before that write.

// File: rtl/rx_type_policy_pkg.sv
`timescale 1ns/1ps
package rx_type_policy_pkg;
  typedef enum logic [1:0] {
    POL_ACCEPT = 2'b00,
    POL_REJECT = 2'b01,
    POL_HOLD   = 2'b10,
    POL_RSVD   = 2'b11
  } pol_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_REJ  = 2'd2,
    ST_HOLD = 2'd3
  } pst_e;
endpackage

// File: rtl/rx_policy_table.sv
`timescale 1ns/1ps
module rx_policy_table
  import rx_type_policy_pkg::*;
#(
  parameter int NUM_TYPES = 16,
  parameter int TW        = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [TW-1:0] cfg_type,
  input  logic [1:0]    cfg_code,
  input  logic          cfg_dflt_we,
  input  logic [1:0]    cfg_dflt_code,
  input  logic [TW-1:0] look_type,
  output pol_e          look_code
);
  localparam int           IDX_W = $clog2(NUM_TYPES);
  localparam logic [TW:0]  LIMIT = (TW+1)'(NUM_TYPES);

  pol_e ent_q [NUM_TYPES];
  pol_e dflt_q;
  logic wr_hit, rd_hit;

  assign wr_hit = cfg_we && ({1'b0, cfg_type} < LIMIT);
  assign rd_hit = {1'b0, look_type} < LIMIT;

  for (genvar g = 0; g < NUM_TYPES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_q[g] <= POL_ACCEPT;
      end else if (wr_hit && cfg_type[IDX_W-1:0] == IDX_W'(g)) begin
        ent_q[g] <= pol_e'(cfg_code);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              dflt_q <= POL_REJECT;
    else if (cfg_dflt_we) dflt_q <= pol_e'(cfg_dflt_code);
  end

  assign look_code = rd_hit ? ent_q[look_type[IDX_W-1:0]] : dflt_q;
endmodule

// File: rtl/rx_hdr_capture.sv
`timescale 1ns/1ps
module rx_hdr_capture #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_start,
  input  logic          cap_more,
  input  logic [DW-1:0] data,
  output logic [1:0]    words_seen,
  output logic [DW-1:0] hdr0,
  output logic [DW-1:0] hdr1
);
  always_ff @(posedge clk) begin
    if (rst) begin
      words_seen <= 2'd0;
      hdr0       <= '0;
      hdr1       <= '0;
    end else if (cap_start) begin
      words_seen <= 2'd1;
      hdr0       <= data;
    end else if (cap_more && words_seen == 2'd1) begin
      words_seen <= 2'd2;
      hdr1       <= data;
    end
  end
endmodule

// File: rtl/rx_policy_fsm.sv
`timescale 1ns/1ps
module rx_policy_fsm
  import rx_type_policy_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_valid,
  input  logic       rx_sof,
  input  logic       rx_eof,
  input  logic       rx_err,
  input  pol_e       code,
  input  logic       host_accept,
  input  logic       host_reject,
  input  logic [1:0] words_seen,
  output logic       cap_start,
  output logic       cap_more,
  output logic       hold_pending,
  output logic       send_rok,
  output logic       send_rerr
);
  pst_e state_q;
  logic err_q, eofs_q, dec_q, acc_q, pend_q, rok_q, rerr_q;
  logic start, word_in, cmd_take;
  logic err_n, eof_n, dec_n, acc_n, good_n;

  always_comb begin
    start    = (state_q == ST_IDLE) && rx_valid && rx_sof;
    word_in  = rx_valid && ((state_q == ST_ACC) || (state_q == ST_REJ) ||
                            ((state_q == ST_HOLD) && !eofs_q));
    cmd_take = (state_q == ST_HOLD) && pend_q && !dec_q && (host_accept || host_reject);
    err_n    = err_q  | (word_in & rx_err);
    eof_n    = eofs_q | (word_in & rx_eof);
    dec_n    = dec_q  | cmd_take;
    acc_n    = cmd_take ? (host_accept & ~host_reject) : acc_q;
    good_n   = acc_n & ~err_n;
  end

  assign cap_start = start;
  assign cap_more  = word_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      eofs_q  <= 1'b0;
      dec_q   <= 1'b0;
      acc_q   <= 1'b0;
      pend_q  <= 1'b0;
      rok_q   <= 1'b0;
      rerr_q  <= 1'b0;
    end else begin
      rok_q  <= 1'b0;
      rerr_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            err_q  <= rx_err;
            eofs_q <= 1'b0;
            dec_q  <= 1'b0;
            acc_q  <= 1'b0;
            unique case (code)
              POL_ACCEPT: begin
                if (rx_eof) begin
                  rok_q  <= ~rx_err;
                  rerr_q <= rx_err;
                end else begin
                  state_q <= ST_ACC;
                end
              end
              POL_HOLD: begin
                state_q <= ST_HOLD;
                if (rx_eof) begin
                  eofs_q <= 1'b1;
                  pend_q <= 1'b1;
                end
              end
              default: begin
                if (rx_eof) rerr_q  <= 1'b1;
                else        state_q <= ST_REJ;
              end
            endcase
          end
        end
        ST_ACC: begin
          if (rx_valid) begin
            err_q <= err_n;
            if (rx_eof) begin
              rok_q   <= ~err_n;
              rerr_q  <= err_n;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_REJ: begin
          if (rx_valid && rx_eof) begin
            rerr_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_HOLD: begin
          err_q  <= err_n;
          eofs_q <= eof_n;
          dec_q  <= dec_n;
          acc_q  <= acc_n;
          if (word_in && !dec_q && (words_seen == 2'd1 || rx_eof)) pend_q <= 1'b1;
          if (cmd_take) pend_q <= 1'b0;
          if (eof_n && dec_n) begin
            rok_q   <= good_n;
            rerr_q  <= ~good_n;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign hold_pending = pend_q;
  assign send_rok     = rok_q;
  assign send_rerr    = rerr_q;

  // R3: acknowledge outputs are mutually exclusive
  p_resp_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(send_rok && send_rerr));
  // R3: outside hold mode a pulse only follows an end-of-frame word
  p_resp_after_eof_r3: assert property (@(posedge clk) disable iff (rst)
    ((send_rok || send_rerr) && $past(state_q) != ST_HOLD) |-> $past(rx_valid && rx_eof));
  // R4: a rejecting frame never produces a good pulse
  p_rej_no_ok_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_REJ) |=> !send_rok);
  // R6: hold flag only while a held frame is in progress
  p_pend_only_hold_r6: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> (state_q == ST_HOLD));
  // R7: no acknowledge for a held frame before a command is taken
  p_hold_waits_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD && !dec_q && !cmd_take) |=> !(send_rok || send_rerr));
  // R8: an error in a held frame blocks a good pulse
  p_err_forces_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD && err_q) |=> !send_rok);
  // R9: hold flag falls only on a host command
  p_pend_fall_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(pend_q) |-> $past(host_accept || host_reject));
endmodule

// File: rtl/rx_type_policy.sv
`timescale 1ns/1ps
module rx_type_policy
  import rx_type_policy_pkg::*;
#(
  parameter int NUM_TYPES = 16,
  parameter int DW        = 32,
  parameter int TW        = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [TW-1:0] cfg_type,
  input  logic [1:0]    cfg_code,
  input  logic          cfg_dflt_we,
  input  logic [1:0]    cfg_dflt_code,
  input  logic          rx_valid,
  input  logic          rx_sof,
  input  logic          rx_eof,
  input  logic          rx_err,
  input  logic [DW-1:0] rx_data,
  input  logic          host_accept,
  input  logic          host_reject,
  output logic          hold_pending,
  output logic [DW-1:0] hdr_dw0,
  output logic [DW-1:0] hdr_dw1,
  output logic          send_rok,
  output logic          send_rerr
);
  pol_e       code;
  logic       cap_start, cap_more;
  logic [1:0] words_seen;

  rx_policy_table #(.NUM_TYPES(NUM_TYPES), .TW(TW)) u_table (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_type(cfg_type), .cfg_code(cfg_code),
    .cfg_dflt_we(cfg_dflt_we), .cfg_dflt_code(cfg_dflt_code),
    .look_type(rx_data[TW-1:0]), .look_code(code)
  );

  rx_hdr_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst(rst),
    .cap_start(cap_start), .cap_more(cap_more), .data(rx_data),
    .words_seen(words_seen), .hdr0(hdr_dw0), .hdr1(hdr_dw1)
  );

  rx_policy_fsm u_fsm (
    .clk(clk), .rst(rst),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
    .code(code), .host_accept(host_accept), .host_reject(host_reject),
    .words_seen(words_seen), .cap_start(cap_start), .cap_more(cap_more),
    .hold_pending(hold_pending), .send_rok(send_rok), .send_rerr(send_rerr)
  );
endmodule

// File: tb/rx_type_policy_tb.sv
`timescale 1ns/1ps
module rx_type_policy_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we, cfg_dflt_we;
  logic [7:0]  cfg_type;
  logic [1:0]  cfg_code, cfg_dflt_code;
  logic        rx_valid, rx_sof, rx_eof, rx_err;
  logic [31:0] rx_data;
  logic        host_accept, host_reject;
  logic        hold_pending, send_rok, send_rerr;
  logic [31:0] hdr_dw0, hdr_dw1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [1:0] sh_tab [16];
  logic [1:0] sh_def;

  always #5 clk = ~clk;

  rx_type_policy dut_i (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_type(cfg_type), .cfg_code(cfg_code),
    .cfg_dflt_we(cfg_dflt_we), .cfg_dflt_code(cfg_dflt_code),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
    .rx_data(rx_data), .host_accept(host_accept), .host_reject(host_reject),
    .hold_pending(hold_pending), .hdr_dw0(hdr_dw0), .hdr_dw1(hdr_dw1),
    .send_rok(send_rok), .send_rerr(send_rerr)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] model_code(input logic [7:0] ty);
    return (ty < 8'd16) ? sh_tab[ty[3:0]] : sh_def;
  endfunction

  task automatic cfg_write(input logic [7:0] ty, input logic [1:0] c);
    cfg_we = 1'b1; cfg_type = ty; cfg_code = c;
    @(negedge clk);
    cfg_we = 1'b0;
    if (ty < 8'd16) sh_tab[ty[3:0]] = c;
  endtask

  task automatic dflt_write(input logic [1:0] c);
    cfg_dflt_we = 1'b1; cfg_dflt_code = c;
    @(negedge clk);
    cfg_dflt_we = 1'b0;
    sh_def = c;
  endtask

  // cmd_at: word index carrying the host command, -1 = after end-of-frame
  task automatic frame(input logic [7:0] ty, input int len, input int err_at,
                       input int cmd_at, input bit acc, input bit rej,
                       input bit cw_same, input logic [1:0] cw_code, input string tag);
    logic [1:0]  c;
    logic [31:0] d0, d1, w;
    bit anyerr, decided, good;
    int dly;
    c = model_code(ty);
    anyerr = 0; d0 = '0; d1 = '0;
    for (int i = 0; i < len; i++) begin
      w = (i == 0) ? {$urandom_range(32'hffffff, 0) & 32'hffffff, 8'h00} | {24'h0, ty} : $urandom;
      if (i == 0) d0 = w;
      if (i == 1) d1 = w;
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == len - 1);
      rx_err = (i == err_at); rx_data = w;
      if (i == err_at) anyerr = 1;
      host_accept = (i == cmd_at) && acc;
      host_reject = (i == cmd_at) && rej;
      cfg_we = (i == 0) && cw_same; cfg_type = ty; cfg_code = cw_code;
      @(negedge clk);
      if (i == 0 && cw_same && ty < 8'd16) sh_tab[ty[3:0]] = cw_code;
      rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
      host_accept = 1'b0; host_reject = 1'b0; cfg_we = 1'b0;
      if (i != len - 1) chk({send_rok, send_rerr}, 2'b00, {tag, " R7 no early ack"});
    end
    chk(hdr_dw0, d0, {tag, " R6 hdr0"});
    if (c == 2'b00) begin
      chk({send_rok, send_rerr}, {~anyerr, anyerr}, {tag, " R3 accept ack"});
    end else if (c == 2'b10) begin
      if (len >= 2) chk(hdr_dw1, d1, {tag, " R6 hdr1"});
      decided = (cmd_at >= 2) && (cmd_at < len);
      if (decided) begin
        good = acc && !rej && !anyerr;
        chk({send_rok, send_rerr}, {good, ~good}, {tag, " R7 R8 ack with early command"});
      end else begin
        chk({send_rok, send_rerr}, 2'b00, {tag, " R7 wait for host"});
        chk(hold_pending, 1'b1, {tag, " R6 hold flag"});
        dly = $urandom_range(3, 0);
        for (int k = 0; k < dly; k++) begin
          @(negedge clk);
          chk({send_rok, send_rerr}, 2'b00, {tag, " R7 still waiting"});
        end
        host_accept = acc; host_reject = rej;
        @(negedge clk);
        host_accept = 1'b0; host_reject = 1'b0;
        good = acc && !rej && !anyerr;
        chk({send_rok, send_rerr}, {good, ~good}, {tag, " R7 R8 ack after command"});
      end
      chk(hold_pending, 1'b0, {tag, " R9 hold flag cleared"});
    end else begin
      chk({send_rok, send_rerr}, 2'b01, {tag, " R4 R5 reject ack"});
    end
    @(negedge clk);
    chk({send_rok, send_rerr}, 2'b00, {tag, " R3 single pulse"});
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    for (int i = 0; i < 16; i++) sh_tab[i] = 2'b00;
    sh_def = 2'b01;
    rst = 1'b1; cfg_we = 0; cfg_dflt_we = 0; cfg_type = 0; cfg_code = 0; cfg_dflt_code = 0;
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0; rx_data = 0;
    host_accept = 0; host_reject = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({send_rok, send_rerr, hold_pending}, 3'b000, "R1 reset outputs");

    frame(8'd3, 4, -1, -1, 0, 0, 0, 0, "R1 R3 accept clean");
    frame(8'd200, 3, -1, -1, 0, 0, 0, 0, "R1 R2 default reject");
    frame(8'd16, 2, -1, -1, 0, 0, 0, 0, "R2 first out of range");
    frame(8'd15, 1, -1, -1, 0, 0, 0, 0, "R2 R3 last in range single word");
    frame(8'd3, 5, 2, -1, 0, 0, 0, 0, "R3 accept with error");
    frame(8'd3, 1, 0, -1, 0, 0, 0, 0, "R3 single word with error");
    cfg_write(8'd5, 2'b01);
    frame(8'd5, 3, -1, -1, 0, 0, 0, 0, "R4 reject code");
    cfg_write(8'd6, 2'b11);
    frame(8'd6, 2, -1, -1, 0, 0, 0, 0, "R5 reserved code");
    cfg_write(8'd7, 2'b10);
    frame(8'd7, 4, -1, -1, 1, 0, 0, 0, "R6 R7 hold accept late");
    frame(8'd7, 4, -1, -1, 0, 1, 0, 0, "R7 hold reject late");
    frame(8'd7, 5, -1, 2, 1, 0, 0, 0, "R7 command before eof");
    frame(8'd7, 3, -1, 2, 1, 0, 0, 0, "R7 command with eof");
    frame(8'd7, 3, -1, -1, 1, 1, 0, 0, "R7 both commands");
    frame(8'd7, 4, 1, -1, 1, 0, 0, 0, "R8 error overrides accept");
    host_accept = 1'b1;
    @(negedge clk);
    host_accept = 1'b0;
    chk({send_rok, send_rerr, hold_pending}, 3'b000, "R9 idle command ignored");
    frame(8'd7, 3, -1, 1, 1, 0, 0, 0, "R9 command before flag ignored");
    frame(8'd7, 1, -1, -1, 1, 0, 0, 0, "R6 single word hold");
    dflt_write(2'b10);
    frame(8'd100, 2, -1, -1, 1, 0, 0, 0, "R2 default hold");
    dflt_write(2'b01);
    frame(8'd3, 2, -1, -1, 0, 0, 1, 2'b01, "R10 write on sof uses old code");
    frame(8'd3, 2, -1, -1, 0, 0, 0, 0, "R10 new code applies next");

    for (int n = 0; n < 80; n++) begin
      logic [7:0] ty;
      int len, ea, ca, dsel;
      if (n % 10 == 0) cfg_write(8'($urandom_range(15, 0)), 2'($urandom_range(3, 0)));
      if (n % 25 == 0) dflt_write(2'($urandom_range(3, 0)));
      ty = ($urandom_range(3, 0) == 0) ? 8'($urandom_range(255, 16)) : 8'($urandom_range(15, 0));
      len = $urandom_range(5, 1);
      ea = ($urandom_range(2, 0) == 0) ? $urandom_range(len - 1, 0) : -1;
      ca = ($urandom_range(1, 0) == 0) ? -1 : $urandom_range(len - 1, 0);
      dsel = $urandom_range(2, 0);
      frame(ty, len, ea, ca, dsel != 1, dsel != 0, 0, 0, "R2 R3 R4 R7 random");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule